// File: doc/BRIEF.md
# Rate-Change Recalibration Flag Sequencer

This controller sits between a user request to reprogram a transceiver and the transceiver's internal configuration bus. When started, it first waits until every calibration engine in the transceiver (PLLs, transmit channels, receive channels) reports idle. Only then does it ask for the bus. Once the bus is granted, it accepts a stream of address/data/mask records and applies each one as a masked register update, using a read followed by a write. The stream is either a complete configuration image or a reduced one that holds only the registers that change.

After the last record, the controller decides the rate-switch flag, which is bit 7 of register 0x166. This flag tells the calibration engine where to take the CDR charge-pump bandwidth from: 1 means reuse its stored copy, 0 means read the values just written. For a reduced stream with a rate change, the controller clears the flag if any record touched a charge-pump field, and sets it otherwise. The lower seven bits of register 0x166 are kept. A full image carries its own flag value, so the controller leaves the flag alone, and a request without a rate change never touches it.

The controller then drops its bus request. With a rate change, it pulses a recalibration trigger and waits for calibration to go busy and then return to idle before it reports completion. The calibration engine sets the flag back to 1 when it finishes, and the controller does not write the flag again.

Top module: `rate_flag_seq`

## Requirements
- R1: After `start`, `bus_req` stays low until every bit of `pll_cal_busy`, `tx_cal_busy` and `rx_cal_busy` is low. `rec_ready` also stays low during that time.
- R2: Each accepted record causes one read of `rec_addr`, then one write to that same address of `(old & ~rec_mask) | (rec_data & rec_mask)`. Only one record is in flight at a time.
- R3: With `full_img`=0 and `rate_chg`=1, if any record has address 0x139 with mask bit 7 set, or address 0x133 with any of mask bits 7..5 set, the controller writes 0x166 with bit 7 = 0. That write happens after the last record, and bits 6..0 keep their previous value.
- R4: With `full_img`=0, `rate_chg`=1 and no such record, the controller writes 0x166 with bit 7 = 1 and bits 6..0 kept.
- R5: With `full_img`=1, the only writes to 0x166 are the ones that records in the stream address.
- R6: With `rate_chg`=0, the controller makes no flag write of its own and gives no `recal_req` pulse. `done` still pulses once the bus is released and all busy inputs are low.
- R7: `m_read` and `m_write` are asserted only while both `bus_req` and `bus_gnt` are high.
- R8: With `rate_chg`=1, `recal_req` pulses for exactly one cycle per request, and only while `bus_req` is low.
- R9: With `rate_chg`=1, `done` pulses only after some calibration-busy input has been seen high and all of them are low again. The controller writes no register after that pulse, so the flag value that calibration restores stays in place.
- R10: A record at 0x139 whose mask leaves bit 7 clear, or a record at 0x133 whose mask leaves bits 7..5 clear, does not count as a charge-pump update.
- R11: During and right after reset, `bus_req`, `rec_ready`, `m_read`, `m_write`, `recal_req` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a reconfiguration request (read in idle) |
| full_img | input | 1 | 1 = full image stream, 0 = reduced stream (latched at start) |
| rate_chg | input | 1 | 1 = request includes a rate change (latched at start) |
| rec_valid | input | 1 | Record valid |
| rec_ready | output | 1 | Record accepted when high with `rec_valid` |
| rec_addr | input | 10 | Record register address |
| rec_data | input | 8 | Record data |
| rec_mask | input | 8 | Record bit write mask |
| rec_last | input | 1 | Marks the final record of the stream |
| pll_cal_busy | input | NUM_PLL | PLL calibration busy |
| tx_cal_busy | input | NUM_CH | Transmit channel calibration busy |
| rx_cal_busy | input | NUM_CH | Receive channel calibration busy |
| bus_req | output | 1 | Request for the configuration bus |
| bus_gnt | input | 1 | Bus granted by the calibration engine |
| m_addr | output | 10 | Master address |
| m_wdata | output | 8 | Master write data |
| m_write | output | 1 | Master write strobe |
| m_read | output | 1 | Master read strobe; data returns on `m_rdata` one cycle later |
| m_rdata | input | 8 | Master read data |
| recal_req | output | 1 | One-cycle recalibration trigger |
| done | output | 1 | One-cycle completion pulse |

## Verification
Assertions check the safety rules on every cycle. The bus is requested only right after all busy inputs were idle. Master accesses happen only under grant. No second record is accepted while one is still being written. The recalibration trigger fires only with the bus released. Completion comes with the bus quiet. Which flag value gets written, whether bits 6..0 of register 0x166 survive, and whether a full or no-rate-change request leaves the flag alone all depend on the content of the stream. Only the bench's scenarios show those, using a register-file model and a calibration-engine model that restores the flag.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int AW = 10;
    localparam int DW = 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
        data_t mask;
    } rec_t;

    localparam addr_t FLAG_ADDR = 10'h166;
    localparam int    FLAG_BIT  = 7;
    localparam data_t FLAG_MASK = data_t'(1) << FLAG_BIT;

    // charge-pump fields whose update forces a fresh bandwidth pickup
    localparam int NUM_CP = 2;

    function automatic addr_t cp_addr(input int idx);
        case (idx)
            0:       return 10'h139;
            default: return 10'h133;
        endcase
    endfunction

    function automatic data_t cp_bits(input int idx);
        case (idx)
            0:       return 8'h80;
            default: return 8'hE0;
        endcase
    endfunction

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT_CAL, S_REQ_BUS, S_STREAM, S_SET_FLAG, S_RELEASE, S_WAIT_RECAL
    } st_t;

    typedef enum logic [1:0] {P_IDLE, P_RD, P_CAP, P_WR} ph_t;
endpackage

// File: rtl/rfs_cal_gate.sv
module rfs_cal_gate #(
    parameter int NUM_PLL = 2,
    parameter int NUM_CH  = 2
) (
    input  logic [NUM_PLL-1:0] pll_busy,
    input  logic [NUM_CH-1:0]  tx_busy,
    input  logic [NUM_CH-1:0]  rx_busy,
    output logic               all_idle
);
    localparam int NB = NUM_PLL + 2 * NUM_CH;
    logic [NB-1:0] busy_all;

    assign busy_all = {pll_busy, tx_busy, rx_busy};
    assign all_idle = ~|busy_all;
endmodule

// File: rtl/rfs_cp_track.sv
module rfs_cp_track
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  rec_t rec,
    output logic cp_hit
);
    logic [NUM_CP-1:0] hit_vec;

    for (genvar i = 0; i < NUM_CP; i++) begin : g_field
        assign hit_vec[i] = upd && (rec.addr == cp_addr(i)) && |(rec.mask & cp_bits(i));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cp_hit <= 1'b0;
        else if (|hit_vec)
            cp_hit <= 1'b1;
    end
endmodule

// File: rtl/rfs_rmw.sv
module rfs_rmw
    import rfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  rec_t  req,
    output logic  idle,
    output logic  fin,
    output addr_t m_addr,
    output data_t m_wdata,
    output logic  m_read,
    output logic  m_write,
    input  data_t m_rdata
);
    ph_t   ph;
    rec_t  hold;
    data_t merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= P_IDLE;
            hold   <= '0;
            merged <= '0;
        end else begin
            case (ph)
                P_IDLE: if (go) begin
                    hold <= req;
                    ph   <= P_RD;
                end
                P_RD:  ph <= P_CAP;
                P_CAP: begin
                    merged <= (m_rdata & ~hold.mask) | (hold.data & hold.mask);
                    ph     <= P_WR;
                end
                default: ph <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        idle    = (ph == P_IDLE);
        fin     = (ph == P_WR);
        m_read  = (ph == P_RD);
        m_write = (ph == P_WR);
        m_addr  = hold.addr;
        m_wdata = merged;
    end

    // R2
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        m_write |-> $past(m_read, 2) && (m_addr == $past(m_addr, 2)));
endmodule

// File: rtl/rate_flag_seq.sv
module rate_flag_seq
    import rfs_pkg::*;
#(
    parameter int NUM_PLL = 2,
    parameter int NUM_CH  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               full_img,
    input  logic               rate_chg,
    input  logic               rec_valid,
    output logic               rec_ready,
    input  logic [AW-1:0]      rec_addr,
    input  logic [DW-1:0]      rec_data,
    input  logic [DW-1:0]      rec_mask,
    input  logic               rec_last,
    input  logic [NUM_PLL-1:0] pll_cal_busy,
    input  logic [NUM_CH-1:0]  tx_cal_busy,
    input  logic [NUM_CH-1:0]  rx_cal_busy,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [AW-1:0]      m_addr,
    output logic [DW-1:0]      m_wdata,
    output logic               m_write,
    output logic               m_read,
    input  logic [DW-1:0]      m_rdata,
    output logic               recal_req,
    output logic               done
);
    st_t  st;
    logic full_q, rate_q, last_q, flag_sent, seen_busy;
    logic all_idle, cp_hit;
    logic rec_acc, flag_go, rmw_go, rmw_idle, rmw_fin;
    rec_t in_rec, rmw_req;
    data_t flag_data;

    rfs_cal_gate #(.NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH)) u_gate (
        .pll_busy (pll_cal_busy),
        .tx_busy  (tx_cal_busy),
        .rx_busy  (rx_cal_busy),
        .all_idle (all_idle)
    );

    rfs_cp_track u_track (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == S_IDLE && start),
        .upd    (rec_acc),
        .rec    (in_rec),
        .cp_hit (cp_hit)
    );

    rfs_rmw u_rmw (
        .clk     (clk),
        .rst     (rst),
        .go      (rmw_go),
        .req     (rmw_req),
        .idle    (rmw_idle),
        .fin     (rmw_fin),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .m_read  (m_read),
        .m_write (m_write),
        .m_rdata (m_rdata)
    );

    always_comb begin
        in_rec     = '{addr: rec_addr, data: rec_data, mask: rec_mask};
        bus_req    = (st == S_REQ_BUS) || (st == S_STREAM) || (st == S_SET_FLAG);
        rec_ready  = (st == S_STREAM) && rmw_idle && !last_q;
        rec_acc    = rec_valid && rec_ready;
        flag_go    = (st == S_SET_FLAG) && !flag_sent;
        rmw_go     = rec_acc || flag_go;
        flag_data  = '0;
        flag_data[FLAG_BIT] = !cp_hit;
        rmw_req    = flag_go ? '{addr: FLAG_ADDR, data: flag_data, mask: FLAG_MASK} : in_rec;
        recal_req  = (st == S_RELEASE) && rate_q;
        done       = (st == S_WAIT_RECAL) && seen_busy && all_idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            full_q    <= 1'b0;
            rate_q    <= 1'b0;
            last_q    <= 1'b0;
            flag_sent <= 1'b0;
            seen_busy <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    full_q <= full_img;
                    rate_q <= rate_chg;
                    last_q <= 1'b0;
                    st     <= S_WAIT_CAL;
                end
                S_WAIT_CAL: if (all_idle) st <= S_REQ_BUS;
                S_REQ_BUS:  if (bus_gnt)  st <= S_STREAM;
                S_STREAM: begin
                    if (rec_acc && rec_last) last_q <= 1'b1;
                    if (rmw_fin && last_q)
                        st <= (rate_q && !full_q) ? S_SET_FLAG : S_RELEASE;
                end
                S_SET_FLAG: begin
                    if (flag_go) flag_sent <= 1'b1;
                    if (rmw_fin) begin
                        flag_sent <= 1'b0;
                        st        <= S_RELEASE;
                    end
                end
                S_RELEASE: begin
                    seen_busy <= !rate_q;
                    st        <= S_WAIT_RECAL;
                end
                S_WAIT_RECAL: begin
                    if (!all_idle) seen_busy <= 1'b1;
                    if (done) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1
    bus_req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(all_idle));

    // R7
    access_granted_chk: assert property (@(posedge clk) disable iff (rst)
        (m_read || m_write) |-> (bus_req && bus_gnt));

    // R8
    recal_released_chk: assert property (@(posedge clk) disable iff (rst)
        recal_req |-> !bus_req);

    // R8
    recal_single_chk: assert property (@(posedge clk) disable iff (rst)
        recal_req |=> !recal_req);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && !m_read && !m_write));

    // R2
    one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        rec_acc |=> !rec_ready);
endmodule

// File: tb/tb_rate_flag_seq.sv
module tb_rate_flag_seq;
    localparam int NUM_PLL = 2;
    localparam int NUM_CH  = 2;

    typedef struct packed {
        logic       full;
        logic       rate;
        logic [9:0] a0;
        logic [7:0] m0;
        logic [7:0] d0;
        logic [9:0] a1;
        logic [7:0] m1;
        logic [7:0] d1;
        logic [1:0] exp_fw;
        logic       exp_fv;
        logic       exp_recal;
    } vec_t;

    // full, rate, a0, m0, d0, a1, m1, d1, flag writes, flag bit, recal
    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b1, 10'h139, 8'h80, 8'h00, 10'h050, 8'hFF, 8'h3C, 2'd1, 1'b0, 1'b1}, // R3
        '{1'b0, 1'b1, 10'h133, 8'h20, 8'hFF, 10'h060, 8'h0F, 8'h05, 2'd1, 1'b0, 1'b1}, // R3
        '{1'b0, 1'b1, 10'h139, 8'h7F, 8'h12, 10'h133, 8'h10, 8'h10, 2'd1, 1'b1, 1'b1}, // R10
        '{1'b0, 1'b1, 10'h070, 8'hFF, 8'hA5, 10'h071, 8'h0F, 8'h0C, 2'd1, 1'b1, 1'b1}, // R4
        '{1'b1, 1'b1, 10'h133, 8'hE0, 8'h40, 10'h166, 8'h80, 8'h00, 2'd1, 1'b0, 1'b1}, // R5
        '{1'b0, 1'b0, 10'h139, 8'h80, 8'h80, 10'h072, 8'hFF, 8'h11, 2'd0, 1'b0, 1'b0}, // R6
        '{1'b1, 1'b1, 10'h080, 8'hFF, 8'h01, 10'h081, 8'hFF, 8'h02, 2'd0, 1'b0, 1'b1}  // R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, full_img = 1'b0, rate_chg = 1'b0;
    logic rec_valid = 1'b0, rec_last = 1'b0;
    logic [9:0] rec_addr = '0;
    logic [7:0] rec_data = '0, rec_mask = '0;
    logic rec_ready;
    logic [NUM_PLL-1:0] pll_cal_busy = '0;
    logic [NUM_CH-1:0]  tx_cal_busy = '0;
    logic [NUM_CH-1:0]  rx_cal_busy;
    logic bus_req, bus_gnt;
    logic [9:0] m_addr;
    logic [7:0] m_wdata, m_rdata;
    logic m_write, m_read, recal_req, done;

    always #5 clk = ~clk;

    rate_flag_seq #(.NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst(rst), .start(start), .full_img(full_img), .rate_chg(rate_chg),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr),
        .rec_data(rec_data), .rec_mask(rec_mask), .rec_last(rec_last),
        .pll_cal_busy(pll_cal_busy), .tx_cal_busy(tx_cal_busy), .rx_cal_busy(rx_cal_busy),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_write(m_write), .m_read(m_read), .m_rdata(m_rdata),
        .recal_req(recal_req), .done(done)
    );

    // register file, grant and calibration engine model
    logic [7:0] mem [1024];
    logic [3:0] cal_cnt;
    int fw_cnt, recal_cnt, viol7, viol8;
    logic [7:0] last_fw;

    assign rx_cal_busy = {NUM_CH{cal_cnt != 0}};

    always @(posedge clk) begin
        if (rst) begin
            bus_gnt <= 1'b0;
            cal_cnt <= '0;
            m_rdata <= '0;
            fw_cnt <= 0; recal_cnt <= 0; viol7 <= 0; viol8 <= 0;
            last_fw <= '0;
        end else begin
            bus_gnt <= bus_req;
            if (m_read) m_rdata <= mem[m_addr];
            if (m_write) mem[m_addr] <= m_wdata;
            if (m_write && m_addr == 10'h166) begin
                fw_cnt  <= fw_cnt + 1;
                last_fw <= m_wdata;
            end
            if ((m_read || m_write) && !bus_gnt) viol7 <= viol7 + 1;
            if (recal_req && bus_req) viol8 <= viol8 + 1;
            if (recal_req) begin
                recal_cnt <= recal_cnt + 1;
                cal_cnt   <= 4'd6;
            end else if (cal_cnt != 0) begin
                cal_cnt <= cal_cnt - 1;
                if (cal_cnt == 4'd1) mem[10'h166][7] <= 1'b1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pre_val(input logic [9:0] a);
        return a[7:0] ^ 8'h5C;
    endfunction

    task automatic send_rec(input logic [9:0] a, input logic [7:0] m, input logic [7:0] d,
                            input logic last);
        bit acc = 0;
        rec_addr = a; rec_mask = m; rec_data = d; rec_last = last; rec_valid = 1'b1;
        for (int i = 0; i < 200; i++) begin
            acc = rec_ready;
            @(negedge clk);
            if (acc) break;
        end
        rec_valid = 1'b0; rec_last = 1'b0;
        check("R2 record accepted", 32'(acc), 32'd1);
    endtask

    task automatic run_vec(input vec_t v, input bit hold_busy);
        int fw0, rc0;
        bit got;
        logic [7:0] e0, e1;
        mem[v.a0] <= pre_val(v.a0);
        mem[v.a1] <= pre_val(v.a1);
        mem[10'h166] <= 8'hB5;
        @(negedge clk);
        fw0 = fw_cnt; rc0 = recal_cnt;
        full_img = v.full; rate_chg = v.rate;
        if (hold_busy) tx_cal_busy = 2'b01;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hold_busy) begin
            repeat (20) @(negedge clk);
            check("R1 no bus_req while busy", 32'(bus_req), 32'd0);
            check("R1 no rec_ready while busy", 32'(rec_ready), 32'd0);
            tx_cal_busy = '0;
        end
        send_rec(v.a0, v.m0, v.d0, 1'b0);
        send_rec(v.a1, v.m1, v.d1, 1'b1);
        got = 0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check("R9 done seen", 32'(got), 32'd1);
        @(negedge clk);
        e0 = (pre_val(v.a0) & ~v.m0) | (v.d0 & v.m0);
        e1 = (pre_val(v.a1) & ~v.m1) | (v.d1 & v.m1);
        if (v.a0 != 10'h166) check("R2 rec0 merged", 32'(mem[v.a0]), 32'(e0));
        if (v.a1 != 10'h166) check("R2 rec1 merged", 32'(mem[v.a1]), 32'(e1));
        check("R3/R4/R5/R6 flag write count", 32'(fw_cnt - fw0), 32'(v.exp_fw));
        if (v.exp_fw != 0)
            check("R3/R4 flag value, bits 6..0 kept", 32'(last_fw), 32'({v.exp_fv, 7'h35}));
        check("R6/R8 recal pulses", 32'(recal_cnt - rc0), 32'(v.exp_recal));
        if (v.exp_recal) begin
            repeat (4) @(negedge clk);
            check("R9 flag restored and not rewritten", 32'(mem[10'h166][7]), 32'd1);
            check("R9 no write after done", 32'(fw_cnt - fw0), 32'(v.exp_fw));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 bus_req in reset", 32'(bus_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 outputs idle after reset",
              32'({bus_req, rec_ready, m_read, m_write, recal_req, done}), 32'd0);

        foreach (VECS[k]) run_vec(VECS[k], 1'b0);

        // R1 directed: busy held before the bus may be requested
        run_vec(VECS[3], 1'b1);
        // back-to-back repeat of a hit case after a no-hit case (tracker clears)
        run_vec(VECS[2], 1'b0);
        run_vec(VECS[0], 1'b0);

        check("R7 accesses only under grant", 32'(viol7), 32'd0);
        check("R8 recal only with bus released", 32'(viol8), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule